// File: doc/BRIEF.md
# Dual-Width Arithmetic-Logic Unit With Status Flags

This block is the arithmetic core of a small processor datapath. Each cycle it takes two operands, an operation code and a width select. It produces the result combinationally, at either the narrow width (8 bits) or the wide width (16 bits). A narrow result is zero-extended on the result port. The operations are add, subtract, increment, decrement, the bitwise AND, OR and XOR, bitwise complement, and a one-place shift in either direction.

Six status flags come from the result and the operands: sign, zero, parity, carry, auxiliary carry and overflow. Each flag follows the selected width. Parity always looks only at the lowest result byte. Auxiliary carry is always the carry or borrow between bits 3 and 4. The flags sit in registers and change only on a clock edge where the update strobe is high. Each operation class updates its own subset of the flags and leaves the others alone. This lets the surrounding control logic compose multi-step sequences without saving and restoring the flags.

Top module: `alu_dual_width`

## Requirements
- R1: The `op_i` code selects the operation: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 increment a, 6 decrement a, 7 complement a, 8 shift a left by one, 9 shift a right by one (zero fill). With `wide_i`=1 the operation works on 16 bits. With `wide_i`=0 it works on the low 8 bits of each operand, and result bits 15:8 are 0.
- R2: On an update, the sign flag becomes the top bit of the result at the selected width. The zero flag becomes 1 exactly when the result is zero.
- R3: On an update, the parity flag becomes 1 exactly when result bits 7:0 hold an even number of ones, at either width.
- R4: For add, carry becomes the carry out of the top bit at the selected width. For subtract, carry becomes the borrow. For add, subtract, increment and decrement, auxiliary carry becomes the carry or borrow from bit 3 into bit 4.
- R5: For add, subtract, increment and decrement, overflow becomes 1 exactly when the signed result does not fit the selected width.
- R6: Increment and decrement update sign, zero, parity, auxiliary and overflow, and leave carry unchanged.
- R7: AND, OR and XOR clear carry, overflow and auxiliary carry, and set sign, zero and parity from the result.
- R8: A left shift puts the old top bit into carry. A right shift puts the old bit 0 into carry. Overflow is 1 when the top bit of the result differs from the top bit of a. Auxiliary carry is cleared.
- R9: Complement, and codes 10 to 15, leave all six flags unchanged. Codes 10 to 15 give a zero result.
- R10: The flags change only on a rising clock edge where `flag_en_i` is 1, and otherwise hold. Reset (`rst_n`=0) clears all six flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Operation code |
| wide_i | input | 1 | 1 selects 16-bit operation, 0 selects 8-bit |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| flag_en_i | input | 1 | Capture the flags of this operation at the next edge |
| result_o | output | 16 | Combinational result, zero-extended in narrow mode |
| sf_o | output | 1 | Sign flag |
| zf_o | output | 1 | Zero flag |
| pf_o | output | 1 | Parity flag |
| cf_o | output | 1 | Carry flag |
| af_o | output | 1 | Auxiliary carry flag |
| of_o | output | 1 | Overflow flag |

## Verification
The bench builds the block with its default parameters: an 8-bit narrow lane and a 16-bit wide lane. At these sizes exhaustive-style edge values are cheap. Directed operand pairs hit the signed and unsigned wrap points at both widths (0x7F/0x80, 0xFF, 0x7FFF/0x8000, 0xFFFF), nibble boundaries for the auxiliary carry, and results whose upper byte is nonzero while the low byte has odd or even parity. A long random run then mixes widths, codes (including the reserved ones) and the update strobe. A behavioural reference model checks the result and all six flags on every cycle.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_SUB = 4'd1,
      OP_AND = 4'd2,
      OP_OR  = 4'd3,
      OP_XOR = 4'd4,
      OP_INC = 4'd5,
      OP_DEC = 4'd6,
      OP_NOT = 4'd7,
      OP_SHL = 4'd8,
      OP_SHR = 4'd9
   } alu_op_e;

   typedef struct packed {
      logic sf;
      logic zf;
      logic pf;
      logic cf;
      logic af;
      logic of;
   } alu_flags_t;

   // which flags an operation class writes
   typedef struct packed {
      logic szp;
      logic cf;
      logic af;
      logic of;
   } flag_mask_t;

   function automatic flag_mask_t mask_for(input logic [3:0] code);
      flag_mask_t m;
      case (code)
         OP_ADD, OP_SUB:         m = '{szp: 1'b1, cf: 1'b1, af: 1'b1, of: 1'b1};
         OP_INC, OP_DEC:         m = '{szp: 1'b1, cf: 1'b0, af: 1'b1, of: 1'b1};
         OP_AND, OP_OR, OP_XOR:  m = '{szp: 1'b1, cf: 1'b1, af: 1'b1, of: 1'b1};
         OP_SHL, OP_SHR:         m = '{szp: 1'b1, cf: 1'b1, af: 1'b1, of: 1'b1};
         default:                m = '{szp: 1'b0, cf: 1'b0, af: 1'b0, of: 1'b0};
      endcase
      return m;
   endfunction

endpackage

// File: rtl/alu_lane.sv
module alu_lane
   import alu_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [3:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] res,
   output logic         cf_raw,
   output logic         af_raw,
   output logic         of_raw
);

   localparam int MSB = W - 1;

   if (W < 8) begin : g_bad_width
      $error("alu_lane: W must be at least 8");
   end

   logic         is_sub;
   logic         use_one;
   logic [W-1:0] opnd;
   logic [W-1:0] opnd_x;
   logic [W:0]   sum;
   logic [W-1:0] nib_x;
   logic         add_cf;
   logic         add_of;

   // one shared adder serves add, subtract, increment and decrement
   always_comb begin
      use_one = (op == OP_INC) || (op == OP_DEC);
      is_sub  = (op == OP_SUB) || (op == OP_DEC);
      opnd    = use_one ? W'(1) : b;
      opnd_x  = is_sub ? ~opnd : opnd;
      sum     = {1'b0, a} + {1'b0, opnd_x} + (W+1)'(is_sub);
      nib_x   = a ^ opnd ^ sum[W-1:0];
      add_cf  = is_sub ? ~sum[W] : sum[W];
      add_of  = (a[MSB] == opnd_x[MSB]) && (sum[MSB] != a[MSB]);
   end

   always_comb begin
      res    = '0;
      cf_raw = 1'b0;
      af_raw = 1'b0;
      of_raw = 1'b0;
      case (op)
         OP_ADD, OP_SUB, OP_INC, OP_DEC: begin
            res    = sum[W-1:0];
            cf_raw = add_cf;
            af_raw = nib_x[4];
            of_raw = add_of;
         end
         OP_AND: res = a & b;
         OP_OR:  res = a | b;
         OP_XOR: res = a ^ b;
         OP_NOT: res = ~a;
         OP_SHL: begin
            res    = {a[MSB-1:0], 1'b0};
            cf_raw = a[MSB];
            of_raw = a[MSB] ^ a[MSB-1];
         end
         OP_SHR: begin
            res    = {1'b0, a[MSB:1]};
            cf_raw = a[0];
            of_raw = a[MSB];
         end
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
   import alu_pkg::*;
#(
   parameter int WIDE_W   = 16,
   parameter int NARROW_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        op,
   input  logic              wide,
   input  logic              en,
   input  logic [WIDE_W-1:0] res,
   input  logic              cf_raw,
   input  logic              af_raw,
   input  logic              of_raw,
   output alu_flags_t        flags
);

   localparam int PAR_W = 8;

   flag_mask_t msk;
   alu_flags_t nxt;
   logic       sign_bit;

   always_comb begin
      msk      = mask_for(op);
      sign_bit = wide ? res[WIDE_W-1] : res[NARROW_W-1];
      nxt      = flags;
      if (msk.szp) begin
         nxt.sf = sign_bit;
         nxt.zf = (res == '0);
         nxt.pf = ~^res[PAR_W-1:0];
      end
      if (msk.cf) nxt.cf = cf_raw;
      if (msk.af) nxt.af = af_raw;
      if (msk.of) nxt.of = of_raw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  flags <= '0;
      else if (en) flags <= nxt;
   end

   p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(flags));

   p_keep_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (op == OP_NOT || op > OP_SHR)) |=> $stable(flags));

   p_keep_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (op == OP_INC || op == OP_DEC)) |=> $stable(flags.cf));

   p_logic_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (op == OP_AND || op == OP_OR || op == OP_XOR))
      |=> (!flags.cf && !flags.of && !flags.af));

   p_shift_aux_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (op == OP_SHL || op == OP_SHR)) |=> !flags.af);

   p_zero_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && op == OP_AND) |=> (flags.zf == ($past(res) == '0)));

endmodule

// File: rtl/alu_dual_width.sv
module alu_dual_width
   import alu_pkg::*;
#(
   parameter int WIDE_W   = 16,
   parameter int NARROW_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        op_i,
   input  logic              wide_i,
   input  logic [WIDE_W-1:0] a_i,
   input  logic [WIDE_W-1:0] b_i,
   input  logic              flag_en_i,
   output logic [WIDE_W-1:0] result_o,
   output logic              sf_o,
   output logic              zf_o,
   output logic              pf_o,
   output logic              cf_o,
   output logic              af_o,
   output logic              of_o
);

   localparam int N_LANES = 2;

   if (NARROW_W < 8 || WIDE_W <= NARROW_W) begin : g_bad_params
      $error("alu_dual_width: need 8 <= NARROW_W < WIDE_W");
   end

   logic [WIDE_W-1:0] lane_res [N_LANES];
   logic              lane_cf  [N_LANES];
   logic              lane_af  [N_LANES];
   logic              lane_of  [N_LANES];

   for (genvar gi = 0; gi < N_LANES; gi++) begin : g_lane
      localparam int LW = (gi == 0) ? NARROW_W : WIDE_W;
      logic [LW-1:0] r;
      alu_lane #(.W(LW)) u_lane (
         .op     (op_i),
         .a      (a_i[LW-1:0]),
         .b      (b_i[LW-1:0]),
         .res    (r),
         .cf_raw (lane_cf[gi]),
         .af_raw (lane_af[gi]),
         .of_raw (lane_of[gi])
      );
      assign lane_res[gi] = WIDE_W'(r);
   end

   logic       sel;
   alu_flags_t flags;

   assign sel      = wide_i;
   assign result_o = lane_res[sel];

   alu_flag_reg #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .op     (op_i),
      .wide   (wide_i),
      .en     (flag_en_i),
      .res    (result_o),
      .cf_raw (lane_cf[sel]),
      .af_raw (lane_af[sel]),
      .of_raw (lane_of[sel]),
      .flags  (flags)
   );

   assign sf_o = flags.sf;
   assign zf_o = flags.zf;
   assign pf_o = flags.pf;
   assign cf_o = flags.cf;
   assign af_o = flags.af;
   assign of_o = flags.of;

   p_narrow_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !wide_i |-> (result_o[WIDE_W-1:NARROW_W] == '0));

   p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i > 4'd9) |-> (result_o == '0));

endmodule

// File: tb/test_alu_dual_width.sv
module test_alu_dual_width;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_i = '0;
   logic        wide_i = 1'b0;
   logic [15:0] a_i = '0;
   logic [15:0] b_i = '0;
   logic        flag_en_i = 1'b0;
   logic [15:0] result_o;
   logic        sf_o, zf_o, pf_o, cf_o, af_o, of_o;

   int n_checks = 0;
   int n_fail   = 0;

   // model flags: index 0 sf,1 zf,2 pf,3 cf,4 af,5 of
   int mf [6];

   always #10 clk = ~clk;

   alu_dual_width i_alu_dual_width (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .wide_i(wide_i),
      .a_i(a_i), .b_i(b_i), .flag_en_i(flag_en_i), .result_o(result_o),
      .sf_o(sf_o), .zf_o(zf_o), .pf_o(pf_o), .cf_o(cf_o), .af_o(af_o), .of_o(of_o)
   );

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic string tag_for(input int op, input int en);
      if (!en) return "R10";
      case (op)
         0, 1:    return "R4";
         5, 6:    return "R6";
         2, 3, 4: return "R7";
         8, 9:    return "R8";
         default: return "R9";
      endcase
   endfunction

   // one cycle: drive, check result, clock, update model, check flags
   task automatic step(input int op, input int wide, input int a, input int b, input int en);
      int w, m, ai, bi, r, c, af, ov, t, ones;
      int nf [6];
      bit wr_szp, wr_c, wr_a, wr_o;
      @(negedge clk);
      op_i = 4'(op); wide_i = wide[0]; a_i = 16'(a); b_i = 16'(b); flag_en_i = en[0];
      w  = wide ? 16 : 8;
      m  = (1 << w) - 1;
      ai = a & m; bi = b & m;
      r = 0; c = 0; af = 0; ov = 0;
      wr_szp = 1; wr_c = 1; wr_a = 1; wr_o = 1;
      case (op)
         0, 5: begin
            t  = (op == 5) ? 1 : bi;
            r  = ai + t; c = (r >> w) & 1; r = r & m;
            af = ((ai & 15) + (t & 15)) > 15 ? 1 : 0;
            ov = (((ai >> (w-1)) & 1) == ((t >> (w-1)) & 1)) && (((r >> (w-1)) & 1) != ((ai >> (w-1)) & 1)) ? 1 : 0;
            if (op == 5) wr_c = 0;
         end
         1, 6: begin
            t  = (op == 6) ? 1 : bi;
            c  = (ai < t) ? 1 : 0; r = (ai - t) & m;
            af = ((ai & 15) < (t & 15)) ? 1 : 0;
            ov = (((ai >> (w-1)) & 1) != ((t >> (w-1)) & 1)) && (((r >> (w-1)) & 1) != ((ai >> (w-1)) & 1)) ? 1 : 0;
            if (op == 6) wr_c = 0;
         end
         2: r = ai & bi;
         3: r = ai | bi;
         4: r = ai ^ bi;
         7: begin r = (~ai) & m; wr_szp = 0; wr_c = 0; wr_a = 0; wr_o = 0; end
         8: begin
            r = (ai << 1) & m; c = (ai >> (w-1)) & 1;
            ov = ((ai >> (w-1)) ^ (ai >> (w-2))) & 1;
         end
         9: begin
            r = ai >> 1; c = ai & 1; ov = (ai >> (w-1)) & 1;
         end
         default: begin r = 0; wr_szp = 0; wr_c = 0; wr_a = 0; wr_o = 0; end
      endcase
      #2;
      check("R1", $sformatf("result op %0d wide %0d", op, wide), int'(result_o), r);
      @(posedge clk);
      #2;
      for (int k = 0; k < 6; k++) nf[k] = mf[k];
      if (en) begin
         ones = 0;
         for (int k = 0; k < 8; k++) ones += (r >> k) & 1;
         if (wr_szp) begin
            nf[0] = (r >> (w-1)) & 1;
            nf[1] = (r == 0) ? 1 : 0;
            nf[2] = (ones % 2 == 0) ? 1 : 0;
         end
         if (wr_c) nf[3] = c;
         if (wr_a) nf[4] = af;
         if (wr_o) nf[5] = ov;
      end
      for (int k = 0; k < 6; k++) mf[k] = nf[k];
      check(en ? "R2" : "R10", "sign",  int'(sf_o), mf[0]);
      check(en ? "R2" : "R10", "zero",  int'(zf_o), mf[1]);
      check(en ? "R3" : "R10", "parity", int'(pf_o), mf[2]);
      check(tag_for(op, en), "carry", int'(cf_o), mf[3]);
      check(tag_for(op, en), "aux",   int'(af_o), mf[4]);
      check((en && (op < 2 || op == 5 || op == 6)) ? "R5" : tag_for(op, en), "overflow", int'(of_o), mf[5]);
   endtask

   initial begin : watchdog
      #5000000;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin : main
      for (int k = 0; k < 6; k++) mf[k] = 0;
      repeat (3) @(posedge clk);
      #2;
      // R10 reset state
      check("R10", "reset flags", int'({sf_o, zf_o, pf_o, cf_o, af_o, of_o}), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R4 R5 add wrap points
      step(0, 0, 16'h007F, 16'h0001, 1);
      step(0, 0, 16'h00FF, 16'h0001, 1);
      step(0, 1, 16'h7FFF, 16'h0001, 1);
      step(0, 1, 16'hFFFF, 16'h0001, 1);
      step(0, 0, 16'h1280, 16'h3480, 1);
      step(0, 1, 16'h000F, 16'h0001, 1);
      // R4 R5 subtract borrow and overflow
      step(1, 0, 16'h0000, 16'h0001, 1);
      step(1, 0, 16'h0080, 16'h0001, 1);
      step(1, 1, 16'h8000, 16'h0001, 1);
      step(1, 1, 16'h0010, 16'h0001, 1);
      // R6 inc/dec keep carry (carry currently from previous step)
      step(0, 0, 16'h00FF, 16'h0001, 1);
      step(5, 0, 16'h00FF, 16'h0000, 1);
      step(6, 1, 16'h8000, 16'h0000, 1);
      step(5, 1, 16'h7FFF, 16'h0000, 1);
      // R7 logic after flags set
      step(0, 1, 16'hFFFF, 16'h8001, 1);
      step(2, 1, 16'hF0F0, 16'h0FF0, 1);
      step(3, 0, 16'hAB00, 16'h0003, 1);
      step(4, 1, 16'h5555, 16'h5555, 1);
      // R3 parity on low byte only
      step(3, 1, 16'h0100, 16'h0001, 1);
      step(3, 1, 16'h0300, 16'h0003, 1);
      // R8 shifts
      step(8, 0, 16'h0040, 16'h0000, 1);
      step(8, 0, 16'h00C0, 16'h0000, 1);
      step(8, 1, 16'h8000, 16'h0000, 1);
      step(9, 1, 16'h8001, 16'h0000, 1);
      step(9, 0, 16'h0081, 16'h0000, 1);
      // R9 complement and reserved codes keep flags
      step(0, 0, 16'h0080, 16'h0080, 1);
      step(7, 0, 16'h0012, 16'h0000, 1);
      step(7, 1, 16'hFFFF, 16'h0000, 1);
      step(12, 1, 16'h1234, 16'h5678, 1);
      step(15, 0, 16'h00FF, 16'h00FF, 1);
      // R10 strobe low holds flags
      step(0, 1, 16'hFFFF, 16'hFFFF, 0);
      step(2, 0, 16'h0000, 16'h0000, 0);

      // random mix
      for (int i = 0; i < 4000; i++) begin
         int rop, rw, ra, rb, ren;
         rop = $urandom_range(0, 15);
         if ($urandom_range(0, 3) != 0) rop = rop % 10;
         rw  = $urandom_range(0, 1);
         ra  = $urandom_range(0, 65535);
         rb  = $urandom_range(0, 65535);
         if ($urandom_range(0, 3) == 0) ra = (rw != 0) ? 16'h7FFF + $urandom_range(0, 2) : 16'h7F + $urandom_range(0, 2);
         ren = ($urandom_range(0, 4) != 0) ? 1 : 0;
         step(rop, rw, ra, rb, ren);
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule